// File: doc/BRIEF.md
# Scratch and Signature Test Window

This block is a small memory-mapped window for bring-up and performance software. It sits on a simple register bus (request valid/ready, address, access size, write data; response valid and read data) and exposes two regions. The first is an 8-byte signature region whose reads return a fixed 32-bit pattern and whose writes go nowhere. Software uses it to time bus round trips. The second is a 64-byte scratch area that accepts writes of any supported size and returns the stored bytes unchanged on later reads. Software uses it to check byte-lane steering and endianness.

The access size is encoded on `req_size` as 0, 1, 2 and 3 for 1, 2, 4 and 8 bytes. Read data is always right-aligned: byte 0 of the access sits in `rsp_rdata[7:0]`. The request is always accepted, and the response appears on the following cycle with no wait states. The base addresses of both regions and the signature value are parameters. Any read that falls in neither region returns ones.

Top module: `testwin`

## Requirements
- R1: After reset, `rsp_valid` is low and every byte of the scratch area reads as 0x00.
- R2: A read at the first signature-region offset returns the 32-bit signature for a 4-byte access, its low 16 bits for a 2-byte access and its low 8 bits for a 1-byte access. An 8-byte access returns the signature in both 32-bit halves.
- R3: A read at signature-region offset k (0 to 7) uses an 8-byte little-endian pattern made of the signature written twice. Result byte i is pattern byte k+i when k+i < 8, and 0xFF when k+i is 8 or more.
- R4: Writes to any signature-region offset are accepted and change no stored state: later signature reads and scratch contents are unchanged.
- R5: A scratch write stores exactly the addressed bytes, with write-data byte i going to scratch byte (offset+i) in little-endian order. A scratch read returns those bytes unchanged, at every size.
- R6: An access hits the scratch area only when offset plus size is no more than 64. An access that straddles the end does not hit: a straddling write changes no scratch byte, and a straddling read returns ones.
- R7: A read that hits neither region returns 0xFF in every byte lane of the access size.
- R8: `req_ready` is always high. An accepted request gives `rsp_valid` high on exactly the next cycle, and an idle cycle gives no response. Write responses carry zero data.
- R9: Response bytes above the access size are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code: 0/1/2/3 = 1/2/4/8 bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_rdata | output | 64 | Read data, right-aligned, upper lanes zero |

## Verification
The hardest case to reach is an access that starts inside the scratch area but runs past its end. In that case the byte index alone would still select valid storage, and only the end-of-access comparison stops the write. The bench fills the last scratch word with known bytes. It then issues 4-byte and 8-byte writes that start a few bytes before the end, and reads the last word back to show that nothing moved. The odd signature offsets are swept at every size, including offset 7 with an 8-byte read, where seven lanes must be padding.

// File: rtl/testwin_pkg.sv
package testwin_pkg;

    localparam int BUS_BYTES = 8;
    localparam int BUS_W     = BUS_BYTES * 8;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_SIG  = 2'd1,
        RG_SCR  = 2'd2
    } region_e;

    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] code);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < BUS_BYTES; i++) begin
            m[8*i +: 8] = (4'(i) < size_bytes(code)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/testwin_decode.sv
module testwin_decode
    import testwin_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SIG_BASE  = 12'h010,
    parameter logic [ADDR_W-1:0] SCR_BASE  = 12'h0C0,
    parameter int                SCR_BYTES = 64,
    localparam int               IDX_W     = $clog2(SCR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output region_e           region,
    output logic [2:0]        sig_off,
    output logic [IDX_W-1:0]  scr_idx
);

    localparam logic [ADDR_W:0] SCR_LIMIT = (ADDR_W+1)'(SCR_BYTES);

    logic [ADDR_W-1:0] sig_rel;
    logic [ADDR_W-1:0] scr_rel;
    logic [ADDR_W:0]   scr_end;
    logic              sig_hit;
    logic              scr_hit;

    assign sig_rel = addr - SIG_BASE;
    assign scr_rel = addr - SCR_BASE;
    assign scr_end = {1'b0, scr_rel} + (ADDR_W+1)'(size_bytes(size));

    // Signature region spans 8 bytes; the access may run past it (padding).
    assign sig_hit = (addr >= SIG_BASE) && (sig_rel < ADDR_W'(8));
    // Scratch needs the whole access inside the area (R6).
    assign scr_hit = (addr >= SCR_BASE) && (scr_end <= SCR_LIMIT);

    assign sig_off = sig_rel[2:0];
    assign scr_idx = scr_rel[IDX_W-1:0];

    always_comb begin
        if (sig_hit)      region = RG_SIG;
        else if (scr_hit) region = RG_SCR;
        else              region = RG_NONE;
    end

    // R7: the two regions never claim the same address.
    p_regions_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sig_hit, scr_hit}));

endmodule

// File: rtl/testwin_sig_gen.sv
module testwin_sig_gen
    import testwin_pkg::*;
#(
    parameter logic [31:0] SIGNATURE = 32'h5A17_C3E9
) (
    input  logic [2:0]       start,
    output logic [BUS_W-1:0] bytes
);

    localparam logic [63:0] PATTERN = {SIGNATURE, SIGNATURE};

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        logic [3:0] pos;
        assign pos = {1'b0, start} + 4'(i);
        assign bytes[8*i +: 8] = pos[3] ? 8'hFF : PATTERN[8*pos[2:0] +: 8];
    end

endmodule

// File: rtl/testwin_scratch.sv
module testwin_scratch
    import testwin_pkg::*;
#(
    parameter  int SCR_BYTES = 64,
    localparam int IDX_W     = $clog2(SCR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       nbytes,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata
);

    typedef logic [SCR_BYTES-1:0][7:0] store_t;

    store_t store_d;
    store_t store_q;

    always_comb begin
        logic [IDX_W-1:0] rel;
        store_d = store_q;
        for (int j = 0; j < SCR_BYTES; j++) begin
            rel = IDX_W'(j) - idx;
            if (wr_en && (rel < IDX_W'(nbytes))) begin
                store_d[j] = wdata[8*rel[2:0] +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_rd
        assign rdata[8*i +: 8] = store_q[idx + IDX_W'(i)];
    end

    // R6: without a write strobe no scratch byte moves.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> store_q == $past(store_q));

    // R5: the first addressed byte lands at the write index.
    p_first_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> store_q[$past(idx)] == $past(wdata[7:0]));

endmodule

// File: rtl/testwin.sv
module testwin
    import testwin_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SIG_BASE  = 12'h010,
    parameter logic [ADDR_W-1:0] SCR_BASE  = 12'h0C0,
    parameter int                SCR_BYTES = 64,
    parameter logic [31:0]       SIGNATURE = 32'h5A17_C3E9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata
);

    localparam int IDX_W = $clog2(SCR_BYTES);

    typedef struct packed {
        logic             vld;
        logic [BUS_W-1:0] data;
    } rsp_t;

    region_e          region;
    logic [2:0]       sig_off;
    logic [IDX_W-1:0] scr_idx;
    logic [BUS_W-1:0] sig_bytes;
    logic [BUS_W-1:0] scr_bytes;
    logic             scr_wr;
    rsp_t             rsp_d;
    rsp_t             rsp_q;

    testwin_decode #(
        .ADDR_W   (ADDR_W),
        .SIG_BASE (SIG_BASE),
        .SCR_BASE (SCR_BASE),
        .SCR_BYTES(SCR_BYTES)
    ) decode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (req_addr),
        .size   (req_size),
        .region (region),
        .sig_off(sig_off),
        .scr_idx(scr_idx)
    );

    testwin_sig_gen #(
        .SIGNATURE(SIGNATURE)
    ) sig_i (
        .start(sig_off),
        .bytes(sig_bytes)
    );

    assign scr_wr = req_valid && req_write && (region == RG_SCR);

    testwin_scratch #(
        .SCR_BYTES(SCR_BYTES)
    ) scratch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (scr_wr),
        .idx   (scr_idx),
        .nbytes(size_bytes(req_size)),
        .wdata (req_wdata),
        .rdata (scr_bytes)
    );

    assign req_ready = 1'b1;

    always_comb begin
        rsp_d.vld  = req_valid;
        rsp_d.data = '0;
        if (req_valid && !req_write) begin
            unique case (region)
                RG_SIG:  rsp_d.data = sig_bytes & lane_mask(req_size);
                RG_SCR:  rsp_d.data = scr_bytes & lane_mask(req_size);
                default: rsp_d.data = lane_mask(req_size);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_rdata = rsp_q.data;

    p_rsp_next_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_write_rsp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> rsp_rdata == '0);

    p_byte_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |=> rsp_rdata[63:8] == '0);

    p_unmapped_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && region == RG_NONE) |=> rsp_rdata[7:0] == 8'hFF);

endmodule

// File: tb/testwin_tb_top.sv
module testwin_tb_top;

    localparam logic [11:0] SIG_B = 12'h010;
    localparam logic [11:0] SCR_B = 12'h0C0;
    localparam logic [31:0] SIG   = 32'h5A17_C3E9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] model [64];

    always #4 clk = ~clk;

    testwin #(
        .ADDR_W(12), .SIG_BASE(SIG_B), .SCR_BASE(SCR_B),
        .SCR_BYTES(64), .SIGNATURE(SIG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] sz);
        return 1 << sz;
    endfunction

    function automatic logic [63:0] exp_sig(input int k, input logic [1:0] sz);
        logic [63:0] r = '0;
        logic [63:0] pat = {SIG, SIG};
        for (int i = 0; i < nb(sz); i++)
            r[8*i +: 8] = (k + i < 8) ? pat[8*(k+i) +: 8] : 8'hFF;
        return r;
    endfunction

    function automatic logic [63:0] ones(input logic [1:0] sz);
        logic [63:0] r = '0;
        for (int i = 0; i < nb(sz); i++) r[8*i +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic logic [63:0] exp_scr(input int off, input logic [1:0] sz);
        logic [63:0] r = '0;
        if (off + nb(sz) > 64) return ones(sz);
        for (int i = 0; i < nb(sz); i++) r[8*i +: 8] = model[off + i];
        return r;
    endfunction

    task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [63:0] wd, output logic [63:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R8 response one cycle after accept", {63'd0, rsp_valid}, 64'd1);
        rd = rsp_rdata;
    endtask

    task automatic scr_write(input int off, input logic [1:0] sz, input logic [63:0] wd);
        logic [63:0] rd;
        acc(1'b1, SCR_B + 12'(off), sz, wd, rd);
        chk("R8 write response data zero", rd, 64'd0);
        if (off + nb(sz) <= 64)
            for (int i = 0; i < nb(sz); i++) model[off + i] = wd[8*i +: 8];
    endtask

    task automatic scr_read(input string tag, input int off, input logic [1:0] sz);
        logic [63:0] rd;
        acc(1'b0, SCR_B + 12'(off), sz, 64'd0, rd);
        chk(tag, rd, exp_scr(off, sz));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        @(negedge clk);
        chk("R1 rsp_valid low in reset", {63'd0, rsp_valid}, 64'd0);
        chk("R8 ready high", {63'd0, req_ready}, 64'd1);
        rst_n = 1'b1;
        for (int w = 0; w < 8; w++) scr_read("R1 scratch zero after reset", 8 * w, 2'd3);
    endtask

    task automatic t_sig_aligned;
        logic [63:0] rd;
        for (int s = 0; s < 4; s++) begin
            acc(1'b0, SIG_B, 2'(s), 64'd0, rd);
            chk("R2 aligned signature read", rd, exp_sig(0, 2'(s)));
        end
        acc(1'b0, SIG_B, 2'd2, 64'd0, rd);
        chk("R2 4-byte signature", rd, {32'd0, SIG});
    endtask

    task automatic t_sig_odd;
        logic [63:0] rd;
        for (int k = 1; k < 8; k++)
            for (int s = 0; s < 4; s++) begin
                acc(1'b0, SIG_B + 12'(k), 2'(s), 64'd0, rd);
                chk("R3 odd signature offset", rd, exp_sig(k, 2'(s)));
            end
        acc(1'b0, SIG_B + 12'd7, 2'd3, 64'd0, rd);
        chk("R3 offset 7 eight bytes", rd, {56'hFF_FFFF_FFFF_FFFF, SIG[31:24]});
    endtask

    task automatic t_sig_write;
        logic [63:0] rd;
        for (int k = 0; k < 8; k++) begin
            acc(1'b1, SIG_B + 12'(k), 2'd3, 64'h0123_4567_89AB_CDEF, rd);
            chk("R4 signature write response", rd, 64'd0);
        end
        acc(1'b0, SIG_B, 2'd3, 64'd0, rd);
        chk("R4 signature unchanged after writes", rd, exp_sig(0, 2'd3));
        scr_read("R4 scratch untouched by signature write", 0, 2'd3);
    endtask

    task automatic t_scratch_sizes;
        scr_write(0, 2'd3, 64'h8877_6655_4433_2211);
        scr_read("R5 8-byte readback", 0, 2'd3);
        scr_write(9, 2'd0, 64'hFFFF_FFFF_FFFF_FFA5);
        scr_write(10, 2'd1, 64'h0000_0000_0000_C3B4);
        scr_write(13, 2'd2, 64'h1111_1111_DEAD_BEEF);
        scr_read("R5 byte write lane", 9, 2'd0);
        scr_read("R5 halfword readback", 10, 2'd1);
        scr_read("R5 unaligned word readback", 13, 2'd2);
        scr_read("R5 neighbours of narrow writes", 8, 2'd3);
        scr_read("R5 cross-word read", 5, 2'd3);
        scr_read("R9 byte read upper lanes zero", 1, 2'd0);
    endtask

    task automatic t_scratch_edge;
        logic [63:0] rd;
        scr_write(56, 2'd3, 64'hF0E1_D2C3_B4A5_9687);
        scr_read("R6 last word inside range", 56, 2'd3);
        scr_write(62, 2'd2, 64'h0000_0000_5555_5555);
        scr_write(60, 2'd3, 64'h6666_6666_6666_6666);
        scr_write(63, 2'd1, 64'h0000_0000_0000_7777);
        scr_read("R6 straddling writes dropped", 56, 2'd3);
        scr_read("R6 straddling word read is ones", 62, 2'd2);
        acc(1'b0, SCR_B + 12'd63, 2'd1, 64'd0, rd);
        chk("R6 straddling halfword read", rd, 64'h0000_0000_0000_FFFF);
        scr_read("R6 final byte inside range", 63, 2'd0);
        scr_read("R6 first word kept", 0, 2'd3);
    endtask

    task automatic t_unmapped;
        logic [63:0] rd;
        acc(1'b0, SIG_B + 12'd8, 2'd3, 64'd0, rd);
        chk("R7 just past signature region", rd, ones(2'd3));
        acc(1'b0, 12'h300, 2'd0, 64'd0, rd);
        chk("R7 unmapped byte read", rd, ones(2'd0));
        acc(1'b0, SCR_B + 12'd64, 2'd2, 64'd0, rd);
        chk("R7 just past scratch", rd, ones(2'd2));
        acc(1'b0, SIG_B - 12'd1, 2'd1, 64'd0, rd);
        chk("R9 unmapped halfword upper lanes zero", rd, 64'h0000_0000_0000_FFFF);
    endtask

    task automatic t_timing;
        @(negedge clk);
        chk("R8 idle gives no response", {63'd0, rsp_valid}, 64'd0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = SIG_B; req_size = 2'd2;
        chk("R8 no response before accepting edge", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        chk("R8 back-to-back first", rsp_rdata, {32'd0, SIG});
        req_addr = 12'h3F0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 back-to-back second valid", {63'd0, rsp_valid}, 64'd1);
        chk("R8 back-to-back second data", rsp_rdata, 64'h0000_0000_FFFF_FFFF);
        @(negedge clk);
        chk("R8 response drops after idle", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        t_sig_aligned;
        t_sig_odd;
        t_sig_write;
        t_scratch_sizes;
        t_scratch_edge;
        t_unmapped;
        t_timing;
        $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
        $finish;
    end

endmodule